// File: doc/BRIEF.md
# Multirate Half-Band Low-Pass Filter

This block is a 55-tap, fixed-coefficient, linear-phase half-band low-pass FIR filter. It runs from a single clock. A 12-bit two's-complement sample enters on each rising edge. Two active-low mode inputs select one of three rates. Equal-rate mode gives one result per input on every clock. Decimate mode filters every input but marks only every other result as valid. Interpolate mode takes an input on every other clock, puts a zero in each empty slot, and produces a result on every clock.

A sync input sets the half-rate phase, and that phase is used by both the decimate and interpolate modes. The output is the full-precision accumulator value with a valid strobe. Rounding, limiting and output formatting are left to the logic that follows the block. The pipeline is fixed: an impulse registered on edge e first shows at the output after edge e+7, peaks after edge e+34 and is last seen after edge e+61.

Top module: `hb_fir`

## Requirements
- R1: While reset is active, `dout` is 0 and `dout_valid` is 0. After reset is released, `dout_valid` stays low until 7 rising edges have passed.
- R2: Let x(e) be the working sample registered on edge e, and let h[j] be tap j (j = 0..54). After edge t, `dout` equals the sum of h[j]·x(t−7−j), with samples before reset taken as zero. An impulse therefore first appears 7 edges after it is registered and last appears 61 edges after.
- R3: The taps are symmetric about j = 27. The centre tap is 32768, which is 0.5 with 16 fractional bits, so an impulse x peaks at x·32768 after 34 edges. Taps at even nonzero offsets from the centre are 0. The taps at odd offsets 1,3,…,27 are 20798, −6773, 3878, −2579, 1819, −1312, 949, −680, 476, −324, 213, −137, 88, −64.
- R4: Equal rate is selected with `interp_n`=1 and `decim_n`=1. In this mode x(e) is `din` on every edge, `dout_valid` is 1 for every result after the pipeline has filled, and `sync` has no effect.
- R5: Decimate is selected with `decim_n`=0 and `interp_n`=1. In this mode x(e) is `din` on every edge. The result after edge e+7 is valid only if edge e was a phase edge, so `dout_valid` alternates.
- R6: Interpolate is selected with `interp_n`=0 and `decim_n`=1. In this mode x(e) is `din` on phase edges and 0 on the other edges, so `din` on non-phase edges has no effect. `dout_valid` is 1 for every result after the pipeline has filled.
- R7: With both mode inputs at 0 (default variant), the block interpolates at unity gain: x(e) is 2·`din` on phase edges and 0 otherwise.
- R8: If `sync` was 1 on the previous edge and is 0 on the current edge, the current edge is a phase edge. After that, phase edges fall on every other edge whether `sync` stays 0 or toggles with 1 on the non-phase edges. After reset, the first phase edge is the one where `sync` first falls, provided `sync` is 1 on the first edge.
- R9: `dout` is the full-precision signed sum with no rounding or clipping. It is exact for full-scale inputs of −2048 and +2047 in every mode, including the doubled samples of R7.
- R10: If `sync` is held at 1 for two edges and then driven to 0, the edge where it falls becomes the new phase edge, and alternation continues from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| interp_n | input | 1 | Active-low interpolate select |
| decim_n | input | 1 | Active-low decimate select |
| sync | input | 1 | Half-rate phase alignment |
| din | input | 12 | Two's-complement input sample |
| dout | output | 32 | Full-precision signed filter result |
| dout_valid | output | 1 | Result strobe |

## Verification
The rate properties assume the mode inputs are held steady for a while before they are checked. The alternating-strobe property also assumes that, while decimating, `sync` is either held low or toggled so that it is low on phase edges. The output-silence property assumes only that enough edges with zero input have passed. The stimulus resets the block before each mode change and gives a single high-then-low sync preamble. It runs resynchronisation sequences only in interpolate mode and random `sync` only in equal-rate mode, so every run meets these assumptions.

// File: rtl/hb_fir.sv
module hb_fir #(
  parameter int IN_W         = 12,
  parameter int HEAD_LAT     = 7,
  parameter bit LOWLOW_UNITY = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   interp_n,
  input  logic                   decim_n,
  input  logic                   sync,
  input  logic [IN_W-1:0]        din,
  output logic signed [IN_W+19:0] dout,
  output logic                   dout_valid
);
  localparam int TAPS  = 55;
  localparam int MID   = (TAPS - 1) / 2;
  localparam int NPAIR = (MID + 1) / 2;
  localparam int CF_W  = 18;
  localparam int ACC_W = IN_W + 20;

  function automatic logic signed [CF_W-1:0] coef(input int m);
    case (m)
      0:  coef = 18'sd20798;
      1:  coef = -18'sd6773;
      2:  coef = 18'sd3878;
      3:  coef = -18'sd2579;
      4:  coef = 18'sd1819;
      5:  coef = -18'sd1312;
      6:  coef = 18'sd949;
      7:  coef = -18'sd680;
      8:  coef = 18'sd476;
      9:  coef = -18'sd324;
      10: coef = 18'sd213;
      11: coef = -18'sd137;
      12: coef = 18'sd88;
      13: coef = -18'sd64;
      default: coef = '0;
    endcase
  endfunction

  logic sync_q, ph_q, take;
  logic signed [IN_W:0]    xin;
  logic signed [IN_W:0]    sr   [TAPS];
  logic signed [ACC_W-1:0] sum;
  logic signed [ACC_W-1:0] pipe [HEAD_LAT];
  logic [HEAD_LAT:0]       vp;

  wire m_unity = ~interp_n & ~decim_n & LOWLOW_UNITY;
  wire m_int   = (~interp_n & decim_n) | m_unity;
  wire m_dec   = interp_n & ~decim_n;

  assign take = sync_q ? ~sync : ph_q;

  always_comb begin
    if (!m_int)     xin = {din[IN_W-1], din};
    else if (!take) xin = '0;
    else if (m_unity) xin = {din, 1'b0};
    else            xin = {din[IN_W-1], din};
  end

  always_comb begin
    sum = ACC_W'(sr[MID]) <<< 15;
    for (int m = 0; m < NPAIR; m++)
      sum = sum + (ACC_W'(sr[MID-1-2*m]) + ACC_W'(sr[MID+1+2*m])) * ACC_W'(coef(m));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      ph_q   <= 1'b0;
      vp     <= '0;
      for (int i = 0; i < TAPS; i++)     sr[i]   <= '0;
      for (int i = 0; i < HEAD_LAT; i++) pipe[i] <= '0;
    end else begin
      sync_q <= sync;
      ph_q   <= ~take;
      vp     <= {vp[HEAD_LAT-1:0], m_dec ? take : 1'b1};
      sr[0]  <= xin;
      for (int i = 1; i < TAPS; i++)     sr[i]   <= sr[i-1];
      pipe[0] <= sum;
      for (int i = 1; i < HEAD_LAT; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign dout       = pipe[HEAD_LAT-1];
  assign dout_valid = vp[HEAD_LAT];
endmodule

module hb_fir_chk #(
  parameter int IN_W     = 12,
  parameter int HEAD_LAT = 7
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    interp_n,
  input logic                    decim_n,
  input logic [IN_W-1:0]         din,
  input logic signed [IN_W+19:0] dout,
  input logic                    dout_valid
);
  localparam int SPAN = HEAD_LAT + 55;

  logic [7:0] rc, mc, zc;
  logic [1:0] mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rc <= '0; mc <= '0; zc <= '0;
      mode_q <= 2'b00;
    end else begin
      mode_q <= {interp_n, decim_n};
      if (rc != 8'hFF) rc <= rc + 8'd1;
      if ({interp_n, decim_n} != mode_q) mc <= '0;
      else if (mc != 8'hFF) mc <= mc + 8'd1;
      if (din != '0) zc <= '0;
      else if (zc != 8'hFF) zc <= zc + 8'd1;
    end
  end

  p_fill_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rc) <= HEAD_LAT) |-> !dout_valid);

  p_silent_after_zeros_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(zc) >= SPAN) |-> (dout == '0));

  p_eq_every_clock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (interp_n && decim_n && int'(mc) >= HEAD_LAT + 2 && int'(rc) > HEAD_LAT) |-> dout_valid);

  p_dec_alternates_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (interp_n && !decim_n && int'(mc) >= HEAD_LAT + 3 && int'(rc) >= HEAD_LAT + 3)
      |-> (dout_valid != $past(dout_valid)));

  p_int_every_clock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!interp_n && decim_n && int'(mc) >= HEAD_LAT + 2 && int'(rc) > HEAD_LAT) |-> dout_valid);
endmodule

bind hb_fir hb_fir_chk #(.IN_W(IN_W), .HEAD_LAT(HEAD_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .interp_n(interp_n), .decim_n(decim_n),
  .din(din), .dout(dout), .dout_valid(dout_valid)
);

// File: tb/sim_hb_fir.sv
module sim_hb_fir;
  localparam int CLK_NS = 10;
  localparam int LAT = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic interp_n = 1'b1, decim_n = 1'b1, sync = 1'b0;
  logic [11:0] din = '0;
  logic signed [31:0] dout;
  logic dout_valid;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;
  longint xs [0:511];
  bit tk [0:511];
  int ctab [14] = '{20798, -6773, 3878, -2579, 1819, -1312, 949, -680, 476, -324, 213, -137, 88, -64};
  logic [15:0] lfsr = 16'hACE1;

  hb_fir u0 (.clk(clk), .rst_n(rst_n), .interp_n(interp_n), .decim_n(decim_n),
             .sync(sync), .din(din), .dout(dout), .dout_valid(dout_valid));

  always #(CLK_NS/2) clk = ~clk;

  function automatic longint htap(input int j);
    int off = j - 27;
    int a = (off < 0) ? -off : off;
    if (off == 0) return 32768;
    if (a % 2 == 0) return 0;
    return ctab[(a - 1) / 2];
  endfunction

  function automatic longint model(input int i);
    longint s = 0;
    for (int j = 0; j < 55; j++)
      if (i - LAT - j >= 0) s += htap(j) * xs[i - LAT - j];
    return s;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // pat: 0 impulse 1000 at edge 3, 1 impulse -2048 at edge 5, 2 lfsr, 3 full-scale alternation
  // sty: 0 sync low after preamble, 1 sync toggling, 2 resync at 40/41, 3 random sync
  // md: 0 equal, 1 decimate, 2 interpolate, 3 unity interpolate
  task automatic run(input int md, input int pat, input int sty, input string tag);
    int d, e;
    bit s, t;
    @(negedge clk);
    rst_n = 1'b0;
    interp_n = (md == 0 || md == 1);
    decim_n  = (md == 0 || md == 2);
    sync = 1'b0; din = '0;
    @(negedge clk);
    chk("R1 reset dout", dout, 0);
    chk("R1 reset valid", longint'(dout_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 140; k++) begin
      if (k > 0) begin
        e = k - 1;
        chk(tag, dout, model(e));
        if (e < LAT) chk("R1 fill valid", longint'(dout_valid), 0);
        else chk({tag, " valid"}, longint'(dout_valid), (md == 1) ? longint'(tk[e - LAT]) : 1);
        if (pat == 0 && md == 0) begin
          if (e == 3 + 6)  chk("R2 before window", dout, 0);
          if (e == 3 + 7)  chk("R2 window start", dout, -64000);
          if (e == 3 + 34) chk("R3 peak", dout, 1000 * 32768);
          if (e == 3 + 61) chk("R2 window end", dout, -64000);
          if (e == 3 + 62) chk("R2 after window", dout, 0);
        end
      end
      case (pat)
        0: d = (k == 3) ? 1000 : 0;
        1: d = (k == 5) ? -2048 : 0;
        2: begin
             lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
             d = int'($signed(lfsr[11:0]));
           end
        default: d = (k % 2 == 0) ? 2047 : -2048;
      endcase
      case (sty)
        0: begin s = (k == 0); t = (k % 2 == 1); end
        1: begin s = (k % 2 == 0); t = (k % 2 == 1); end
        2: begin s = (k == 0 || k == 40 || k == 41);
                 t = (k < 40) ? (k % 2 == 1) : (k >= 42 && k % 2 == 0); end
        default: begin s = lfsr[3] ^ k[0]; t = 1'b0; end
      endcase
      sync = s;
      din = d[11:0];
      tk[k] = t;
      if (md == 2)      xs[k] = t ? longint'(d) : 0;
      else if (md == 3) xs[k] = t ? 2 * longint'(d) : 0;
      else              xs[k] = d;
      @(negedge clk);
    end
  endtask

  initial begin
    run(0, 0, 0, "R2 equal impulse");
    run(0, 2, 3, "R4 equal random sync ignored");
    run(0, 3, 0, "R9 equal full scale");
    run(1, 0, 0, "R5 decimate impulse");
    run(1, 2, 1, "R5 R8 decimate toggled sync");
    run(1, 1, 0, "R5 decimate negative impulse");
    run(2, 0, 0, "R6 interpolate impulse");
    run(2, 2, 0, "R6 interpolate skips odd slots");
    run(2, 2, 1, "R8 interpolate toggled sync");
    run(2, 2, 2, "R10 interpolate resync");
    run(3, 2, 0, "R7 unity interpolate");
    run(3, 3, 1, "R9 unity full scale");
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule